// File: doc/BRIEF.md
# Memory Error Syndrome Capture Register

This block records where the first memory error in a group of on-chip RAMs occurred. Each RAM instance, or a group of them, drives one of several parallel error report ports. A report carries a strobe, a 7-bit RAM identifier, a 3-bit bank/way code, a 12-bit row index and a fatal flag. The first report latches its location and sets a sticky valid bit. Later reports are then counted. A report at the same location counts as a repeat. A report at any other location counts as an "other" error. Both counts saturate.

A fatal report from one of the two RAMs allowed to raise one moves the recorded location to that report, even after the register is already valid. It also sets a sticky fatal bit. The whole 64-bit syndrome is always visible on a read bus. A single write strobe clears every field to zero, and the value written is irrelevant.

Top module: `mem_err_syndrome`

## Requirements
- R1: The read word places Fatal at bit 63, the other-error count at 47:40, the repeat count at 39:32, Valid at bit 31, the RAM identifier at 30:24, the bank/way code at 20:18 and the index at 11:0. Bits 62:48, 23:21 and 17:12 always read as zero.
- R2: After reset the read word is zero. A cycle with `wr_en` high clears the word to zero on the next clock edge. A report arriving in that same cycle is discarded.
- R3: Valid becomes 1 on the clock edge that follows the first report seen while it is 0. It then stays 1 until a write.
- R4: A first error stores the identifier, way and index of one report and leaves both counts at zero. When several reports arrive together, a qualifying fatal report wins over non-fatal ones. Among equals, the lowest-numbered port wins.
- R5: While Valid is 1, a cycle in which at least one report matches the stored identifier, way and index adds exactly one to the repeat count.
- R6: While Valid is 1, a cycle in which at least one report differs from the stored location in any field adds exactly one to the other count, however many such reports arrive.
- R7: A fatal flag counts only when the identifier is 0x09 or 0x0A; on any other identifier it is ignored. Once set, Fatal stays 1 until a write.
- R8: While Valid is 1, a qualifying fatal report replaces the stored location with its own, taken from the lowest-numbered fatal port. It is still counted against the old location.
- R9: Both counts stop at 255 and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rpt_vld | input | NUM_PORTS | Per-port error strobe |
| rpt_id | input | NUM_PORTS*7 | Per-port RAM identifier, port p at bits [p*7 +: 7] |
| rpt_way | input | NUM_PORTS*3 | Per-port bank/way code, port p at bits [p*3 +: 3] |
| rpt_idx | input | NUM_PORTS*12 | Per-port row index, port p at bits [p*12 +: 12] |
| rpt_fatal | input | NUM_PORTS | Per-port fatal flag |
| wr_en | input | 1 | Write strobe, clears the register |
| rd_data | output | 64 | Current syndrome word |

## Verification
The checker assumes that all report inputs carry known values on every clock edge. It also assumes that no report arrives during the two cycles in which the internal reset is still held after `rst_n` rises, because a first-error property would otherwise see a dropped report. The bench drives every input at the falling edge and keeps all strobes low from reset until four cycles after release. Identifiers outside the fatal-capable pair are used with the fatal flag set, so that the filtering assumption of R7 is covered from both sides.

// File: rtl/mesr_pkg.sv
package mesr_pkg;
  localparam int ID_W  = 7;
  localparam int WAY_W = 3;
  localparam int IDX_W = 12;
  localparam int CNT_W = 8;

  localparam logic [ID_W-1:0] FATAL_ID_DATA  = 7'h09;
  localparam logic [ID_W-1:0] FATAL_ID_DIRTY = 7'h0A;

  // bit positions of the 64-bit read word
  localparam int POS_FATAL = 63;
  localparam int POS_OTHER = 40;
  localparam int POS_REP   = 32;
  localparam int POS_VALID = 31;
  localparam int POS_ID    = 24;
  localparam int POS_WAY   = 18;
  localparam int POS_IDX   = 0;

  typedef struct packed {
    logic [ID_W-1:0]  id;
    logic [WAY_W-1:0] way;
    logic [IDX_W-1:0] idx;
  } err_loc_t;
endpackage

// File: rtl/mesr_rst_sync.sv
module mesr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/mesr_sat_cnt.sv
module mesr_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic         en;

  always_comb begin
    en    = clr | (inc & (cnt_q != MAX));
    cnt_d = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/mesr_arbiter.sv
module mesr_arbiter
  import mesr_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic [NUM_PORTS-1:0]     vld,
  input  logic [NUM_PORTS-1:0]     fatal,
  input  err_loc_t [NUM_PORTS-1:0] loc,
  input  err_loc_t                 stored,
  output logic                     any_err,
  output logic                     any_match,
  output logic                     any_miss,
  output logic                     any_fatal,
  output err_loc_t                 win_loc
);
  logic [NUM_PORTS-1:0] fat_ok;
  err_loc_t             low_loc, fat_loc;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_qual
    assign fat_ok[p] = vld[p] & fatal[p] &
                       ((loc[p].id == FATAL_ID_DATA) | (loc[p].id == FATAL_ID_DIRTY));
  end

  // iterate downward so the lowest-numbered port is assigned last
  always_comb begin
    any_err   = 1'b0;
    any_match = 1'b0;
    any_miss  = 1'b0;
    any_fatal = 1'b0;
    low_loc   = '0;
    fat_loc   = '0;
    for (int p = NUM_PORTS - 1; p >= 0; p--) begin
      if (vld[p]) begin
        any_err = 1'b1;
        low_loc = loc[p];
        if (loc[p] == stored) any_match = 1'b1;
        else                  any_miss  = 1'b1;
      end
      if (fat_ok[p]) begin
        any_fatal = 1'b1;
        fat_loc   = loc[p];
      end
    end
    win_loc = any_fatal ? fat_loc : low_loc;
  end
endmodule

// File: rtl/mem_err_syndrome.sv
module mem_err_syndrome
  import mesr_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_PORTS-1:0]       rpt_vld,
  input  logic [NUM_PORTS*ID_W-1:0]  rpt_id,
  input  logic [NUM_PORTS*WAY_W-1:0] rpt_way,
  input  logic [NUM_PORTS*IDX_W-1:0] rpt_idx,
  input  logic [NUM_PORTS-1:0]       rpt_fatal,
  input  logic                       wr_en,
  output logic [63:0]                rd_data
);
  logic rst_i_n;

  mesr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  err_loc_t [NUM_PORTS-1:0] loc_in;
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_unpack
    assign loc_in[p].id  = rpt_id [p*ID_W  +: ID_W];
    assign loc_in[p].way = rpt_way[p*WAY_W +: WAY_W];
    assign loc_in[p].idx = rpt_idx[p*IDX_W +: IDX_W];
  end

  logic     valid_q, valid_d, fatal_q, fatal_d;
  err_loc_t loc_q, loc_d;
  logic     any_err, any_match, any_miss, any_fatal;
  err_loc_t win_loc;

  mesr_arbiter #(.NUM_PORTS(NUM_PORTS)) u_arb (
    .vld       (rpt_vld),
    .fatal     (rpt_fatal),
    .loc       (loc_in),
    .stored    (loc_q),
    .any_err   (any_err),
    .any_match (any_match),
    .any_miss  (any_miss),
    .any_fatal (any_fatal),
    .win_loc   (win_loc)
  );

  logic             cnt_clr, inc_rep, inc_oth;
  logic [CNT_W-1:0] rep_cnt, oth_cnt;

  always_comb begin
    cnt_clr = wr_en | (~valid_q & any_err);
    inc_rep = ~wr_en & valid_q & any_match;
    inc_oth = ~wr_en & valid_q & any_miss;
  end

  mesr_sat_cnt #(.W(CNT_W)) u_rep (
    .clk (clk), .rst_n (rst_i_n), .clr (cnt_clr), .inc (inc_rep), .cnt (rep_cnt)
  );

  mesr_sat_cnt #(.W(CNT_W)) u_oth (
    .clk (clk), .rst_n (rst_i_n), .clr (cnt_clr), .inc (inc_oth), .cnt (oth_cnt)
  );

  // next state of the sticky bits and the recorded location
  always_comb begin
    valid_d = valid_q;
    fatal_d = fatal_q;
    loc_d   = loc_q;
    if (wr_en) begin
      valid_d = 1'b0;
      fatal_d = 1'b0;
      loc_d   = '0;
    end else if (!valid_q && any_err) begin
      valid_d = 1'b1;
      fatal_d = any_fatal;
      loc_d   = win_loc;
    end else if (valid_q && any_fatal) begin
      fatal_d = 1'b1;
      loc_d   = win_loc;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      valid_q <= 1'b0;
      fatal_q <= 1'b0;
      loc_q   <= '0;
    end else begin
      valid_q <= valid_d;
      fatal_q <= fatal_d;
      loc_q   <= loc_d;
    end
  end

  always_comb begin
    rd_data                              = '0;
    rd_data[POS_FATAL]                   = fatal_q;
    rd_data[POS_OTHER +: CNT_W]          = oth_cnt;
    rd_data[POS_REP   +: CNT_W]          = rep_cnt;
    rd_data[POS_VALID]                   = valid_q;
    rd_data[POS_ID    +: ID_W]           = loc_q.id;
    rd_data[POS_WAY   +: WAY_W]          = loc_q.way;
    rd_data[POS_IDX   +: IDX_W]          = loc_q.idx;
  end
endmodule

// File: rtl/mesr_checker.sv
module mesr_checker #(
  parameter int NUM_PORTS = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_PORTS-1:0]    rpt_vld,
  input logic [NUM_PORTS*7-1:0]  rpt_id,
  input logic [NUM_PORTS-1:0]    rpt_fatal,
  input logic                    wr_en,
  input logic [63:0]             rd_data
);
  logic fat_in;
  always_comb begin
    fat_in = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (rpt_vld[p] && rpt_fatal[p] &&
          (rpt_id[p*7 +: 7] == 7'h09 || rpt_id[p*7 +: 7] == 7'h0A))
        fat_in = 1'b1;
  end

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[62:48] == '0 && rd_data[23:21] == '0 && rd_data[17:12] == '0);

  assert_write_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == 64'd0);

  assert_valid_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31] && !wr_en |=> rd_data[31]);

  assert_first_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[31] && !wr_en && (|rpt_vld) |=> rd_data[31] && rd_data[47:32] == '0);

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en && rpt_vld == '0 |=> $stable(rd_data));

  assert_other_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> {1'b0, rd_data[47:40]} >= {1'b0, $past(rd_data[47:40])} &&
               {1'b0, rd_data[47:40]} <= {1'b0, $past(rd_data[47:40])} + 9'd1);

  assert_fatal_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[63] && !wr_en |=> rd_data[63]);

  assert_fatal_filter_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[63] && !fat_in |=> !rd_data[63]);

  assert_rep_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> {1'b0, rd_data[39:32]} >= {1'b0, $past(rd_data[39:32])} &&
               {1'b0, rd_data[39:32]} <= {1'b0, $past(rd_data[39:32])} + 9'd1);
endmodule

bind mem_err_syndrome mesr_checker #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rpt_vld   (rpt_vld),
  .rpt_id    (rpt_id),
  .rpt_fatal (rpt_fatal),
  .wr_en     (wr_en),
  .rd_data   (rd_data)
);

// File: tb/mem_err_syndrome_test.sv
module mem_err_syndrome_test;
  localparam int NP = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NP-1:0]   rpt_vld = '0;
  logic [NP*7-1:0] rpt_id = '0;
  logic [NP*3-1:0] rpt_way = '0;
  logic [NP*12-1:0] rpt_idx = '0;
  logic [NP-1:0]   rpt_fatal = '0;
  logic            wr_en = 1'b0;
  logic [63:0]     rd_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mem_err_syndrome #(.NUM_PORTS(NP)) uut (
    .clk (clk), .rst_n (rst_n), .rpt_vld (rpt_vld), .rpt_id (rpt_id),
    .rpt_way (rpt_way), .rpt_idx (rpt_idx), .rpt_fatal (rpt_fatal),
    .wr_en (wr_en), .rd_data (rd_data)
  );

  typedef struct packed {
    logic [1:0]  port;
    logic [6:0]  id;
    logic [2:0]  way;
    logic [11:0] idx;
    logic        fat;
    logic        vld;
    logic        wr;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 7'h09, 3'd2, 12'h123, 1'b0, 1'b1, 1'b0, 64'h0000_0000_8908_0123}, // R3 R4 first
    '{2'd1, 7'h09, 3'd2, 12'h123, 1'b0, 1'b1, 1'b0, 64'h0000_0001_8908_0123}, // R5 repeat
    '{2'd2, 7'h18, 3'd1, 12'h123, 1'b0, 1'b1, 1'b0, 64'h0000_0101_8908_0123}, // R6 id differs
    '{2'd3, 7'h09, 3'd2, 12'h124, 1'b0, 1'b1, 1'b0, 64'h0000_0201_8908_0123}, // R6 idx differs
    '{2'd0, 7'h08, 3'd0, 12'h007, 1'b1, 1'b1, 1'b0, 64'h0000_0301_8908_0123}, // R7 fatal ignored
    '{2'd1, 7'h0A, 3'd0, 12'h055, 1'b1, 1'b1, 1'b0, 64'h8000_0401_8A00_0055}, // R8 overwrite
    '{2'd2, 7'h0A, 3'd0, 12'h055, 1'b0, 1'b1, 1'b0, 64'h8000_0402_8A00_0055}, // R5 new loc
    '{2'd0, 7'h00, 3'd0, 12'h000, 1'b0, 1'b0, 1'b1, 64'h0000_0000_0000_0000}, // R2 write
    '{2'd3, 7'h01, 3'd1, 12'hFFF, 1'b1, 1'b1, 1'b0, 64'h0000_0000_8104_0FFF}, // R7 first, not fatal
    '{2'd0, 7'h0A, 3'd0, 12'h000, 1'b1, 1'b1, 1'b0, 64'h8000_0100_8A00_0000}, // R8
    '{2'd0, 7'h09, 3'd0, 12'h001, 1'b1, 1'b1, 1'b1, 64'h0000_0000_0000_0000}, // R2 write wins
    '{2'd0, 7'h00, 3'd0, 12'h000, 1'b0, 1'b0, 1'b0, 64'h0000_0000_0000_0000}, // R2 dropped
    '{2'd2, 7'h09, 3'd7, 12'hABC, 1'b1, 1'b1, 1'b0, 64'h8000_0000_891C_0ABC}, // R1 R7 fatal first
    '{2'd0, 7'h00, 3'd0, 12'h000, 1'b0, 1'b0, 1'b1, 64'h0000_0000_0000_0000}  // R2
  };

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic clr_ports();
    rpt_vld = '0; rpt_fatal = '0; rpt_id = '0; rpt_way = '0; rpt_idx = '0; wr_en = 1'b0;
  endtask

  task automatic set_port(input int p, input logic [6:0] id, input logic [2:0] way,
                          input logic [11:0] idx, input logic fat);
    rpt_vld[p] = 1'b1;
    rpt_fatal[p] = fat;
    rpt_id[p*7 +: 7] = id;
    rpt_way[p*3 +: 3] = way;
    rpt_idx[p*12 +: 12] = idx;
  endtask

  // drive at a falling edge, let one rising edge pass, sample at the next falling edge
  task automatic step();
    @(negedge clk);
    clr_ports();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    clr_ports();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    do_reset();
    check("R2 reset", rd_data, 64'd0);

    for (int i = 0; i < NV; i++) begin
      clr_ports();
      if (VECS[i].vld) set_port(int'(VECS[i].port), VECS[i].id, VECS[i].way, VECS[i].idx, VECS[i].fat);
      wr_en = VECS[i].wr;
      step();
      check($sformatf("table %0d (R1..R9 per row)", i), rd_data, VECS[i].exp);
    end
    check("R1 reserved bits", rd_data & 64'h7FFF_0000_00E3_F000, 64'd0);

    // R4: lowest port wins among non-fatal first errors
    set_port(1, 7'h18, 3'd1, 12'h010, 1'b0);
    set_port(2, 7'h00, 3'd0, 12'h020, 1'b0);
    step();
    check("R4 low port wins", rd_data, 64'h0000_0000_9804_0010);

    // R6: three differing reports in one cycle add one
    set_port(0, 7'h00, 3'd0, 12'h020, 1'b0);
    set_port(1, 7'h01, 3'd1, 12'h010, 1'b0);
    set_port(3, 7'h08, 3'd1, 12'h010, 1'b0);
    step();
    check("R6 several others count once", rd_data, 64'h0000_0100_9804_0010);

    // R5: two matching reports in one cycle add one
    set_port(0, 7'h18, 3'd1, 12'h010, 1'b0);
    set_port(3, 7'h18, 3'd1, 12'h010, 1'b0);
    step();
    check("R5 several repeats count once", rd_data, 64'h0000_0101_9804_0010);

    // R9: repeat count saturates
    for (int k = 0; k < 260; k++) begin
      set_port(0, 7'h18, 3'd1, 12'h010, 1'b0);
      step();
    end
    check("R9 repeat saturates", rd_data, 64'h0000_01FF_9804_0010);

    for (int k = 0; k < 260; k++) begin
      set_port(2, 7'h18, 3'd2, 12'h010, 1'b0);
      step();
    end
    check("R9 other saturates", rd_data, 64'h0000_FFFF_9804_0010);

    wr_en = 1'b1;
    step();
    check("R2 write clears", rd_data, 64'd0);

    // R4 R7: a qualifying fatal on a higher port beats a lower non-fatal port
    set_port(0, 7'h01, 3'd0, 12'h001, 1'b0);
    set_port(3, 7'h09, 3'd3, 12'h200, 1'b1);
    step();
    check("R4 fatal priority", rd_data, 64'h8000_0000_890C_0200);

    // R8: lowest fatal port chosen when two fatal reports arrive
    set_port(1, 7'h0A, 3'd0, 12'h011, 1'b1);
    set_port(2, 7'h09, 3'd5, 12'h022, 1'b1);
    step();
    check("R8 lowest fatal port", rd_data, 64'h8000_0100_8A00_0011);

    // R2: asynchronous reset mid-run
    do_reset();
    check("R2 reset mid-run", rd_data, 64'd0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule